// File: doc/BRIEF.md
# Node Supply Power-Mode and Reset Sequencer

This block is the digital controller of a small node power supply. It decides when the local voltage regulator runs and when the node's reset line is released. Three things start the regulator: power-on, the enable pin going high, or a wake-up pulse seen on the serial bus. It stops when the enable pin falls. An over-temperature event forces it off. After the chip cools down, a full start-up follows, whatever the levels on the enable pin and the bus.

On every start-up the block waits until the supply clears its low threshold. It then probes a strap pin once. It reads the strap level, pulls the pin toward the opposite level for a single clock cycle, and reads the pin again. The first reading selects the reset threshold: low means the low threshold, high means the high threshold. Whether the level moved under the pull selects the reset delay. A strap tied directly to a rail holds its level and selects the long delay. A strap connected through a resistor follows the pull and selects the short delay. Once the delay has run while the supply stays above the chosen threshold, the reset output goes high. A supply dip that lasts long enough pulls reset low again. All time intervals are derived from the clock frequency parameter, so the block runs straight from the node's oscillator.

Top module: `node_supply_seq`

## Requirements
- R1: While `rst_n` is low, `reg_en_o` is 1, `reset_n_o` is 0, `thr_hi_o` is 0, and both strap pulls are 0. A start-up sequence begins when `rst_n` is released.
- R2: With the regulator off, a bus run of either level that lasts at least WAKE_CYC consecutive samples starts a start-up. The run must follow a bus level that was itself held for at least WAKE_CYC samples. Runs shorter than that leave the regulator off. WAKE_CYC is CLK_HZ·45 µs.
- R3: A falling edge on `en_i` turns the regulator off and drives reset low in any powered state. A low level on `en_i` after a bus wake does not turn it off. A high `en_i` while off starts a start-up.
- R4: During a start-up, once `vcc_lo_i` is 1 the strap level is read. The next cycle drives exactly one pull for exactly one cycle: `strap_pu_o` if the read level was 0, `strap_pd_o` if it was 1.
- R5: `thr_hi_o` takes the strap level read before the pull and holds it until the next start-up. While it is 1, the supply is judged by `vcc_hi_i`; while it is 0, by `vcc_lo_i`.
- R6: `reset_n_o` rises after the selected supply flag has been 1 for T consecutive cycles, counted from the cycle after the pull. T is 100 ms of clock cycles if the strap kept its level under the pull, and 15 ms if it flipped. Cycles with the flag at 0 restart the count.
- R7: While reset is high, the selected supply flag at 0 for RR_CYC consecutive cycles (CLK_HZ·TRR_US) drops `reset_n_o`, and the R6 delay then starts again. Shorter dips leave reset high.
- R8: `ot_i` at 1 turns the regulator off on the next cycle from any state. The regulator then ignores `en_i` and the bus until `cool_i` is 1. That starts a full start-up, which stays on even with `en_i` low.
- R9: `reset_n_o` is 0 whenever the regulator is off and throughout a start-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| en_i | input | 1 | Enable pin level |
| bus_i | input | 1 | Bus line level |
| ot_i | input | 1 | Over-temperature flag |
| cool_i | input | 1 | Cool-down flag |
| vcc_lo_i | input | 1 | Supply above the low reset threshold |
| vcc_hi_i | input | 1 | Supply above the high reset threshold |
| strap_i | input | 1 | Strap pin read-back level |
| reg_en_o | output | 1 | Regulator enable |
| reset_n_o | output | 1 | Node reset, active low |
| thr_hi_o | output | 1 | Selected reset threshold (1 = high) |
| strap_pu_o | output | 1 | Strap pull-up current enable |
| strap_pd_o | output | 1 | Strap pull-down current enable |

## Verification
The assertions assume that every input is already synchronous to `clk`, and that `en_i` is low while `rst_n` is asserted. They also assume that `ot_i` and `cool_i` are never 1 together, and that the strap read-back settles within the single pull cycle. The bench changes every input only on the falling clock edge. It models the strap as a combinational function of the two pull outputs for each of the four strap connections. It keeps the over-temperature and cool-down flags as separate one-at-a-time pulses.

// File: rtl/node_supply_seq.sv
module node_supply_seq #(
  parameter int CLK_HZ        = 1_000_000,
  parameter int WAKE_US       = 45,
  parameter int TRES_LONG_MS  = 100,
  parameter int TRES_SHORT_MS = 15,
  parameter int TRR_US        = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bus_i,
  input  logic ot_i,
  input  logic cool_i,
  input  logic vcc_lo_i,
  input  logic vcc_hi_i,
  input  logic strap_i,
  output logic reg_en_o,
  output logic reset_n_o,
  output logic thr_hi_o,
  output logic strap_pu_o,
  output logic strap_pd_o
);
  localparam int WAKE_CYC  = int'(longint'(CLK_HZ) * WAKE_US / 1_000_000);
  localparam int LONG_CYC  = int'(longint'(CLK_HZ) * TRES_LONG_MS / 1_000);
  localparam int SHORT_CYC = int'(longint'(CLK_HZ) * TRES_SHORT_MS / 1_000);
  localparam int RR_CYC    = int'(longint'(CLK_HZ) * TRR_US / 1_000_000);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam int DW = $clog2(LONG_CYC + 1);
  localparam int UW = $clog2(RR_CYC + 1);
  localparam logic [WW-1:0] WAKE_W  = WW'(WAKE_CYC);
  localparam logic [DW-1:0] LONG_M1 = DW'(LONG_CYC - 1);
  localparam logic [DW-1:0] SHRT_M1 = DW'(SHORT_CYC - 1);
  localparam logic [UW-1:0] RR_M1   = UW'(RR_CYC - 1);

  typedef enum logic [2:0] {S_OFF, S_WAITV, S_READ, S_PULL, S_DELAY, S_RUN, S_HOT} st_t;
  st_t st, nxt;

  logic          en_q, bus_q, armed, s0, thr_q, short_q;
  logic [WW-1:0] wcnt;
  logic [DW-1:0] dcnt;
  logic [UW-1:0] ucnt;
  logic          vcc_ok, en_fall, bus_edge, wake;
  logic [DW-1:0] tres_m1;

  assign vcc_ok   = thr_q ? vcc_hi_i : vcc_lo_i;
  assign en_fall  = en_q & ~en_i;
  assign bus_edge = bus_i ^ bus_q;
  assign wake     = armed && (wcnt == WAKE_W);
  assign tres_m1  = short_q ? SHRT_M1 : LONG_M1;

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:   if (en_i || wake) nxt = S_WAITV;
      S_WAITV: if (vcc_lo_i) nxt = S_READ;
      S_READ:  nxt = S_PULL;
      S_PULL:  nxt = S_DELAY;
      S_DELAY: if (vcc_ok && dcnt == tres_m1) nxt = S_RUN;
      S_RUN:   if (!vcc_ok && ucnt == RR_M1) nxt = S_DELAY;
      S_HOT:   if (cool_i) nxt = S_WAITV;
      default: nxt = S_OFF;
    endcase
    if (st != S_OFF && st != S_HOT && en_fall) nxt = S_OFF;
    if (ot_i) nxt = S_HOT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_WAITV;
      en_q    <= 1'b0;
      bus_q   <= 1'b1;
      armed   <= 1'b0;
      wcnt    <= WAKE_W;
      dcnt    <= '0;
      ucnt    <= '0;
      s0      <= 1'b0;
      thr_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      st    <= nxt;
      en_q  <= en_i;
      bus_q <= bus_i;
      if (st != S_OFF) begin
        armed <= 1'b0;
        wcnt  <= WAKE_W;
      end else if (bus_edge) begin
        armed <= (wcnt == WAKE_W);
        wcnt  <= WW'(1);
      end else if (wcnt != WAKE_W) begin
        wcnt  <= wcnt + 1'b1;
      end
      dcnt <= (st == S_DELAY && vcc_ok) ? dcnt + 1'b1 : '0;
      ucnt <= (st == S_RUN && !vcc_ok) ? ucnt + 1'b1 : '0;
      if (st == S_READ) s0 <= strap_i;
      if (st == S_PULL) begin
        thr_q   <= s0;
        short_q <= (strap_i != s0);
      end
    end
  end

  assign reg_en_o   = (st != S_OFF) && (st != S_HOT);
  assign reset_n_o  = (st == S_RUN);
  assign thr_hi_o   = thr_q;
  assign strap_pu_o = (st == S_PULL) && !s0;
  assign strap_pd_o = (st == S_PULL) && s0;
endmodule

// File: rtl/node_supply_seq_chk.sv
module node_supply_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic ot_i,
  input logic cool_i,
  input logic vcc_lo_i,
  input logic vcc_hi_i,
  input logic reg_en_o,
  input logic reset_n_o,
  input logic thr_hi_o,
  input logic strap_pu_o,
  input logic strap_pd_o
);
  p_off_holds_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en_o |-> !reset_n_o);

  p_hot_turns_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |=> !reg_en_o);

  p_en_fall_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && $past(en_i) && !cool_i) |=> !reg_en_o);

  p_pull_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_pu_o || strap_pd_o) |=> !(strap_pu_o || strap_pd_o));

  p_pull_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strap_pu_o && strap_pd_o));

  p_rise_needs_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_o) |-> $past(thr_hi_o ? vcc_hi_i : vcc_lo_i));

  p_thr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_n_o |-> $stable(thr_hi_o));
endmodule

bind node_supply_seq node_supply_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .ot_i(ot_i), .cool_i(cool_i),
  .vcc_lo_i(vcc_lo_i), .vcc_hi_i(vcc_hi_i), .reg_en_o(reg_en_o),
  .reset_n_o(reset_n_o), .thr_hi_o(thr_hi_o), .strap_pu_o(strap_pu_o),
  .strap_pd_o(strap_pd_o)
);

// File: tb/sim_node_supply_seq.sv
`timescale 1ns/1ps
module sim_node_supply_seq;
  localparam int HZ    = 200_000;
  localparam int WAKE  = HZ * 45 / 1_000_000;
  localparam int LONG  = HZ * 100 / 1_000;
  localparam int SHORT = HZ * 15 / 1_000;
  localparam int RR    = HZ * 50 / 1_000_000;
  // [3:2] strap: 0 gnd, 1 vcc, 2 res-gnd, 3 res-vcc; [1] thr_hi; [0] short delay
  localparam logic [3:0] VEC [4] = '{4'b00_0_0, 4'b10_0_1, 4'b01_1_0, 4'b11_1_1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_i = 1'b0, bus_i = 1'b1, ot_i = 1'b0, cool_i = 1'b0;
  logic vcc_lo_i = 1'b1, vcc_hi_i = 1'b1, strap_i;
  logic reg_en_o, reset_n_o, thr_hi_o, strap_pu_o, strap_pd_o;
  logic [1:0] smode = 2'd0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  always_comb
    case (smode)
      2'd0: strap_i = 1'b0;
      2'd1: strap_i = 1'b1;
      2'd2: strap_i = strap_pu_o;
      default: strap_i = ~strap_pd_o;
    endcase

  node_supply_seq #(.CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .bus_i(bus_i), .ot_i(ot_i),
    .cool_i(cool_i), .vcc_lo_i(vcc_lo_i), .vcc_hi_i(vcc_hi_i), .strap_i(strap_i),
    .reg_en_o(reg_en_o), .reset_n_o(reset_n_o), .thr_hi_o(thr_hi_o),
    .strap_pu_o(strap_pu_o), .strap_pd_o(strap_pd_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic probe(input logic exp_thr, input logic exp_short, input string tag);
    int n = 0;
    int t = exp_short ? SHORT : LONG;
    while (!(strap_pu_o || strap_pd_o) && n < 50) begin @(negedge clk); n++; end
    chk(n < 50, {"R4 pull seen ", tag}, n, 0);
    chk(strap_pu_o == !exp_thr && strap_pd_o == exp_thr, {"R4 pull dir ", tag},
        {strap_pu_o, strap_pd_o}, {!exp_thr, exp_thr});
    @(negedge clk);
    n = 1;
    chk(!(strap_pu_o || strap_pd_o), {"R4 one cycle ", tag}, {strap_pu_o, strap_pd_o}, 0);
    while (!reset_n_o && n < 25000) begin @(negedge clk); n++; end
    chk(n == t + 1, {"R6 delay ", tag}, n, t + 1);
    chk(thr_hi_o == exp_thr, {"R5 thr ", tag}, thr_hi_o, exp_thr);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(190_000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    wait_n(3);
    chk(reg_en_o && !reset_n_o && !thr_hi_o && !strap_pu_o && !strap_pd_o, "R1 reset state",
        {reg_en_o, reset_n_o, thr_hi_o, strap_pu_o, strap_pd_o}, 5'b10000);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      smode = VEC[i][3:2];
      en_i = 1'b1; wait_n(2);
      en_i = 1'b0; wait_n(2);
      chk(!reg_en_o && !reset_n_o, "R3 en fall off", {reg_en_o, reset_n_o}, 0);
      en_i = 1'b1;
      probe(VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));
    end

    // R7 with the high threshold selected: vcc_hi alone matters
    vcc_hi_i = 1'b0; wait_n(RR - 1); vcc_hi_i = 1'b1; wait_n(2);
    chk(reset_n_o, "R7 short dip ignored", reset_n_o, 1);
    vcc_hi_i = 1'b0; wait_n(RR);
    chk(!reset_n_o, "R7 dip drops reset", reset_n_o, 0);
    vcc_hi_i = 1'b1;
    begin
      int n = 0;
      while (!reset_n_o && n < 25000) begin @(negedge clk); n++; end
      chk(n == SHORT, "R7 re-delay", n, SHORT);
    end

    // R2 wake from a low pulse, R3 low EN keeps it on
    en_i = 1'b0; wait_n(2);
    chk(!reg_en_o, "R3 off", reg_en_o, 0);
    bus_i = 1'b0; wait_n(WAKE - 1); bus_i = 1'b1; wait_n(3 * WAKE);
    chk(!reg_en_o, "R2 short low pulse ignored", reg_en_o, 0);
    bus_i = 1'b0; wait_n(WAKE); bus_i = 1'b1; wait_n(3);
    chk(reg_en_o && !reset_n_o, "R2 low pulse wakes, R9 reset low", {reg_en_o, reset_n_o}, 2'b10);
    bus_i = 1'b0; wait_n(10);
    chk(reg_en_o, "R3 low EN level keeps on", reg_en_o, 1);
    en_i = 1'b1; wait_n(2); en_i = 1'b0; wait_n(2);
    chk(!reg_en_o, "R3 high-low turns off", reg_en_o, 0);

    // R2 high pulse from a low idle bus
    bus_i = 1'b1; wait_n(WAKE - 1); bus_i = 1'b0; wait_n(3 * WAKE);
    chk(!reg_en_o, "R2 short high pulse ignored", reg_en_o, 0);
    bus_i = 1'b1; wait_n(WAKE); bus_i = 1'b0; wait_n(3);
    chk(reg_en_o, "R2 high pulse wakes", reg_en_o, 1);
    bus_i = 1'b1; wait_n(5);

    // R8 over-temperature and cool-down
    ot_i = 1'b1; @(negedge clk); ot_i = 1'b0;
    chk(!reg_en_o && !reset_n_o, "R8 hot off", {reg_en_o, reset_n_o}, 0);
    en_i = 1'b1; wait_n(5); en_i = 1'b0;
    bus_i = 1'b0; wait_n(2 * WAKE); bus_i = 1'b1; wait_n(3);
    chk(!reg_en_o, "R8 en and bus ignored while hot", reg_en_o, 0);
    cool_i = 1'b1; @(negedge clk); cool_i = 1'b0;
    chk(reg_en_o, "R8 cool restarts", reg_en_o, 1);
    probe(1'b1, 1'b1, "after cool");
    chk(reg_en_o, "R8 on with EN low", reg_en_o, 1);

    summary();
  end
endmodule